// File: doc/BRIEF.md
# Edge-Selectable Digital Phase-Frequency Detector

This block compares a reference clock against a feedback clock and produces pump-request pulses for a charge pump further down the loop. Both clocks are sampled by a fast system clock. Each one passes through a synchronizer, and then an edge detector that picks out the comparison edge. A single select input sets that edge to rising or to falling, and the choice applies to both inputs at once.

The core is a three-state detector. If the reference edge arrives first, the pump-up request rises. If the feedback edge arrives first, the pump-down request rises. When the other side's edge arrives, both requests are high for exactly one cycle and then both clear. A request is therefore only issued around a detector event. Between events the two requests stay low, so the loop holds its control value.

If the feedback clock stops, the up request stays high, which drives the oscillator toward its highest frequency. A power-down input clears all state and silences the outputs. A lock indicator rises after a run of comparisons whose one-sided pulse stayed narrow.

Top module: `pfd_edge_sel`

## Requirements
- R1: After synchronous reset, `pump_up`, `pump_dn` and `lock_ok` are all 0.
- R2: When `edge_fall` is 0, only 0-to-1 transitions of `ref_clk` and `fb_clk` are compared. When it is 1, only 1-to-0 transitions are compared. Transitions in the other direction never cause a pulse.
- R3: An active edge on an input that changes just after a system-clock rising edge raises its request at the third following rising edge. At the default two-stage synchronizer this is the sample taken two cycles after the first one.
- R4: If the reference edge leads the feedback edge by d cycles, `pump_up` is high alone for exactly d cycles and `pump_dn` never goes high alone. If the feedback edge leads by d cycles, the two roles swap.
- R5: Edges on both inputs that are detected in the same cycle, with no request pending, produce no pulse on either output.
- R6: A cycle in which both requests are high is always followed by a cycle in which they are not both high. Each comparison with a nonzero offset contains exactly one such cycle.
- R7: While the block is enabled and no feedback edge arrives, `pump_up` stays high continuously once it has been raised, and `pump_dn` stays 0.
- R8: While `pwr_dn` is 1, both requests are 0 from the next cycle on. A request that was pending is forgotten, so after release a lone feedback edge raises `pump_dn` and not the overlap.
- R9: `lock_ok` rises after 16 consecutive comparisons whose one-sided pulse lasted at most 2 cycles. A coincident pair counts as width 0.
- R10: `lock_ok` falls when a one-sided pulse reaches 3 cycles, or on power-down. Between events both requests stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_dn | input | 1 | Power-down: clears state, silences outputs |
| edge_fall | input | 1 | 0 compares rising edges, 1 compares falling edges |
| ref_clk | input | 1 | Reference clock, asynchronous |
| fb_clk | input | 1 | Feedback clock, asynchronous |
| pump_up | output | 1 | Request to raise oscillator frequency |
| pump_dn | output | 1 | Request to lower oscillator frequency |
| lock_ok | output | 1 | Run of narrow comparisons reached |

## Verification
A wrong synchronizer depth or edge polarity shows up in the first comparison. The request rises in the wrong sample, or it reacts to the return-to-idle edges. A fault in the tri-state core changes the number of one-sided cycles, or stretches or drops the one-cycle overlap, which is visible within one comparison window. A missed clear on power-down appears one cycle after power-down is asserted, and again on the first edge after release. A miscounted run length in the lock logic moves the rise of `lock_ok` off the sixteenth comparison, or keeps it high after a wide pulse.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  typedef enum logic {
    EDGE_RISE = 1'b0,
    EDGE_FALL = 1'b1
  } edge_pol_e;

  localparam int unsigned PFD_LANES = 2;
  localparam int unsigned LANE_REF  = 0;
  localparam int unsigned LANE_FB   = 1;
endpackage

// File: rtl/pfd_edge_det.sv
module pfd_edge_det #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic pol,
  input  logic din,
  output logic ev
);
  localparam int unsigned DEPTH = STAGES + 1;

  logic [DEPTH-1:0] sh_q;
  logic cur, hist;

  always_ff @(posedge clk) begin
    if (rst || clr) sh_q <= '0;
    else            sh_q <= {sh_q[DEPTH-2:0], din};
  end

  assign cur  = sh_q[STAGES-1];
  assign hist = sh_q[STAGES];
  assign ev   = (pol == pfd_pkg::EDGE_FALL) ? (hist & ~cur) : (~hist & cur);

  AST_EV_SINGLE: assert property (@(posedge clk) disable iff (rst || clr)
    ev && $stable(pol) |=> !ev || !$stable(pol)); // R2
endmodule

// File: rtl/pfd_tristate.sv
module pfd_tristate (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic ref_ev,
  input  logic fb_ev,
  output logic up_q,
  output logic dn_q,
  output logic coin_q
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      up_q   <= 1'b0;
      dn_q   <= 1'b0;
      coin_q <= 1'b0;
    end else if (up_q && dn_q) begin
      up_q   <= ref_ev && !fb_ev;
      dn_q   <= fb_ev && !ref_ev;
      coin_q <= ref_ev && fb_ev;
    end else if (!up_q && !dn_q && ref_ev && fb_ev) begin
      up_q   <= 1'b0;
      dn_q   <= 1'b0;
      coin_q <= 1'b1;
    end else begin
      up_q   <= up_q | ref_ev;
      dn_q   <= dn_q | fb_ev;
      coin_q <= 1'b0;
    end
  end

  AST_COINCIDENT: assert property (@(posedge clk) disable iff (rst || clr)
    !up_q && !dn_q && ref_ev && fb_ev |=> !up_q && !dn_q); // R5
  AST_UP_HOLD: assert property (@(posedge clk) disable iff (rst || clr)
    up_q && !dn_q && !fb_ev |=> up_q); // R7
endmodule

// File: rtl/pfd_lock.sv
module pfd_lock #(
  parameter int unsigned LOCK_RUNS = 16,
  parameter int unsigned WIDTH_TOL = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic up_i,
  input  logic dn_i,
  input  logic coin_i,
  output logic locked_q
);
  localparam int unsigned WW = $clog2(WIDTH_TOL + 2);
  localparam int unsigned CW = $clog2(LOCK_RUNS + 1);
  localparam logic [WW-1:0] TOL_V = WW'(WIDTH_TOL);
  localparam logic [WW-1:0] SAT_V = WW'(WIDTH_TOL + 1);
  localparam logic [CW-1:0] RUN_V = CW'(LOCK_RUNS);

  logic [WW-1:0] wcnt_q;
  logic [CW-1:0] run_q;
  logic single, done;

  assign single = up_i ^ dn_i;
  assign done   = up_i & dn_i;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wcnt_q   <= '0;
      run_q    <= '0;
      locked_q <= 1'b0;
    end else begin
      if (single) wcnt_q <= (wcnt_q == SAT_V) ? wcnt_q : wcnt_q + 1'b1;
      else        wcnt_q <= '0;
      if (single && wcnt_q >= TOL_V) begin
        run_q    <= '0;
        locked_q <= 1'b0;
      end else if ((done && wcnt_q <= TOL_V) || coin_i) begin
        if (run_q != RUN_V) run_q <= run_q + 1'b1;
        locked_q <= (run_q + 1'b1 >= RUN_V);
      end
    end
  end

  AST_LOCK_DROP: assert property (@(posedge clk) disable iff (rst || clr)
    single && wcnt_q == TOL_V |=> !locked_q); // R10
endmodule

// File: rtl/pfd_edge_sel.sv
module pfd_edge_sel #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned LOCK_RUNS   = 16,
  parameter int unsigned WIDTH_TOL   = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pwr_dn,
  input  logic edge_fall,
  input  logic ref_clk,
  input  logic fb_clk,
  output logic pump_up,
  output logic pump_dn,
  output logic lock_ok
);
  import pfd_pkg::*;

  logic [PFD_LANES-1:0] lane_in;
  logic [PFD_LANES-1:0] lane_ev;
  logic coin;

  assign lane_in[LANE_REF] = ref_clk;
  assign lane_in[LANE_FB]  = fb_clk;

  for (genvar g = 0; g < PFD_LANES; g++) begin : g_lane
    pfd_edge_det #(.STAGES(SYNC_STAGES)) u_det (
      .clk (clk),
      .rst (rst),
      .clr (pwr_dn),
      .pol (edge_fall),
      .din (lane_in[g]),
      .ev  (lane_ev[g])
    );
  end

  pfd_tristate u_core (
    .clk    (clk),
    .rst    (rst),
    .clr    (pwr_dn),
    .ref_ev (lane_ev[LANE_REF]),
    .fb_ev  (lane_ev[LANE_FB]),
    .up_q   (pump_up),
    .dn_q   (pump_dn),
    .coin_q (coin)
  );

  pfd_lock #(.LOCK_RUNS(LOCK_RUNS), .WIDTH_TOL(WIDTH_TOL)) u_lock (
    .clk      (clk),
    .rst      (rst),
    .clr      (pwr_dn),
    .up_i     (pump_up),
    .dn_i     (pump_dn),
    .coin_i   (coin),
    .locked_q (lock_ok)
  );

  AST_OVERLAP_ONE: assert property (@(posedge clk) disable iff (rst)
    pump_up && pump_dn |=> !(pump_up && pump_dn)); // R6
  AST_PD_QUIET: assert property (@(posedge clk) disable iff (rst)
    pwr_dn |=> !pump_up && !pump_dn && !lock_ok); // R8
endmodule

// File: tb/pfd_edge_sel_bench.sv
module pfd_edge_sel_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pwr_dn = 1'b0;
  logic edge_fall = 1'b0;
  logic ref_clk = 1'b0;
  logic fb_clk = 1'b0;
  logic pump_up, pump_dn, lock_ok;
  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  pfd_edge_sel u_pfd_edge_sel (
    .clk(clk), .rst(rst), .pwr_dn(pwr_dn), .edge_fall(edge_fall),
    .ref_clk(ref_clk), .fb_clk(fb_clk),
    .pump_up(pump_up), .pump_dn(pump_dn), .lock_ok(lock_ok)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // One comparison: d>0 reference leads by d cycles, d<0 feedback leads.
  task automatic compare(input bit pol, input int d);
    int uo = 0, dno = 0, both = 0, fu = -1, fd = -1, stray = 0;
    int rt = (d < 0) ? -d : 0;
    int ft = (d > 0) ? d : 0;
    edge_fall = pol;
    ref_clk = pol;
    fb_clk = pol;
    for (int i = 0; i < 6; i++) step();
    for (int i = 0; i < 16; i++) begin
      if (i == rt) ref_clk = ~pol;
      if (i == ft) fb_clk = ~pol;
      step();
      if (pump_up && !pump_dn) uo++;
      if (pump_dn && !pump_up) dno++;
      if (pump_up && pump_dn) both++;
      if (pump_up && fu < 0) fu = i;
      if (pump_dn && fd < 0) fd = i;
    end
    chk(uo == ((d > 0) ? d : 0), "R4", "up-only cycles", uo, (d > 0) ? d : 0);
    chk(dno == ((d < 0) ? -d : 0), "R4", "dn-only cycles", dno, (d < 0) ? -d : 0);
    chk(both == ((d != 0) ? 1 : 0), (d == 0) ? "R5" : "R6", "overlap cycles",
        both, (d != 0) ? 1 : 0);
    if (d != 0) begin
      chk(fu == rt + 2, "R3", "first up sample", fu, rt + 2);
      chk(fd == ft + 2, "R3", "first dn sample", fd, ft + 2);
    end
    ref_clk = pol;
    for (int i = 0; i < 3; i++) begin
      step();
      if (pump_up || pump_dn) stray++;
    end
    fb_clk = pol;
    for (int i = 0; i < 8; i++) begin
      step();
      if (pump_up || pump_dn) stray++;
    end
    chk(stray == 0, "R2", "pulses on inactive edges", stray, 0);
  endtask

  initial begin
    #2_000_000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int run = 0;
    @(negedge clk);
    step();
    step();
    rst = 1'b0;
    step();
    chk(!pump_up && !pump_dn && !lock_ok, "R1", "outputs after reset",
        {pump_up, pump_dn, lock_ok}, 0);

    for (int p = 0; p < 2; p++)
      for (int d = -4; d <= 4; d++) compare(p[0], d);

    // Lock run: R9 / R10
    pwr_dn = 1'b1;
    step();
    pwr_dn = 1'b0;
    chk(!lock_ok, "R10", "lock cleared by power-down", lock_ok, 0);
    for (int k = 0; k < 15; k++) compare(1'b0, (k % 2 == 0) ? 2 : -2);
    chk(!lock_ok, "R9", "lock after 15 runs", lock_ok, 0);
    compare(1'b0, 0);
    chk(lock_ok, "R9", "lock after 16 runs", lock_ok, 1);
    compare(1'b0, 3);
    chk(!lock_ok, "R10", "lock after 3-cycle pulse", lock_ok, 0);

    // Missing feedback: R7
    edge_fall = 1'b0;
    ref_clk = 1'b0;
    fb_clk = 1'b0;
    for (int i = 0; i < 6; i++) step();
    for (int i = 0; i < 40; i++) begin
      if (i % 4 == 0) ref_clk = ~ref_clk;
      step();
      if (i >= 2 && (!pump_up || pump_dn)) run++;
    end
    chk(run == 0, "R7", "cycles without steady up", run, 0);

    // Power-down: R8
    pwr_dn = 1'b1;
    ref_clk = 1'b0;
    step();
    chk(!pump_up && !pump_dn, "R8", "outputs in power-down", {pump_up, pump_dn}, 0);
    step();
    pwr_dn = 1'b0;
    for (int i = 0; i < 5; i++) step();
    chk(!pump_up && !pump_dn, "R10", "idle after release", {pump_up, pump_dn}, 0);
    fb_clk = 1'b1;
    step();
    step();
    step();
    chk(pump_dn && !pump_up, "R8", "lone dn after release", {pump_up, pump_dn}, 1);
    step();
    step();
    chk(pump_dn && !pump_up, "R8", "dn held, no stale up", {pump_up, pump_dn}, 1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule